// File: doc/BRIEF.md
# Bidirectional Bit Scan Unit

This block locates a set bit inside a source word and reports its position. In upward mode it returns the position of the lowest set bit. In downward mode it returns the position of the highest set bit. The search runs over either the low 16 bits or the full 32 bits, as a size input selects. One priority search serves both directions: for a downward scan the active word is bit-reversed before it reaches the encoder, and the index is mirrored on the way out.

An execution pipeline drives a request with `valid_i`. It reads back the index, a zero flag and a write enable one clock later. When no bit is set within the active width, the zero flag rises, the write enable stays low and the index output keeps the last value written. The destination therefore never takes an undefined value. With the `REG_OUT` parameter cleared, the result stage is combinational and the latency is zero. The default build is registered.

Top module: `bit_scan_unit`

## Requirements
- R1: In upward mode (`rev_i` = 0), a request with at least one active bit set produces on `idx_o` the position of the lowest set active bit, counted from 0 at bit 0.
- R2: In downward mode (`rev_i` = 1), a request with at least one active bit set produces on `idx_o` the position of the highest set active bit.
- R3: In 16-bit mode (`size32_i` = 0), source bits 31:16 take no part in the search. Every index written in this mode lies in 0..15, so `idx_o[4]` is 0.
- R4: In 32-bit mode (`size32_i` = 1), all 32 source bits are searched and indices reach up to 31.
- R5: `zf_o` is 1 after a request whose active bits are all zero. It is 0 after a request with any active bit set.
- R6: After a request whose active bits are all zero, `wr_en_o` is 0 and `idx_o` keeps its previous value. After a request with an active bit set, `wr_en_o` is 1.
- R7: With the default registered output, `valid_o` equals `valid_i` of the previous cycle, and `wr_en_o` is 1 only in a cycle where `valid_o` is 1.
- R8: While `rst_ni` is low, `idx_o`, `zf_o`, `wr_en_o` and `valid_o` are all 0.
- R9: In a cycle without a request (`valid_i` = 0), `idx_o` and `zf_o` keep their values and `wr_en_o` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe for the current inputs |
| src_i | input | 32 | Source word to search |
| rev_i | input | 1 | 0: lowest set bit first, 1: highest set bit first |
| size32_i | input | 1 | 0: search bits 15:0 only, 1: search all 32 bits |
| idx_o | output | 5 | Index of the found bit, or the last written index |
| zf_o | output | 1 | No bit set within the active width |
| wr_en_o | output | 1 | The index was updated by this result |
| valid_o | output | 1 | A result is presented |

## Verification
The checker takes for granted that `rev_i`, `size32_i` and `src_i` carry defined values whenever `valid_i` is high. It also assumes that these inputs change only between clock edges, since the properties compare the outputs against the sampled inputs of the previous cycle. The bench drives every input on the falling edge and holds it through the next rising edge. Its requests cover both directions, both sizes, all-zero words, words that are zero only in their low half, and single-bit words at both ends, followed by random traffic mixed with idle cycles.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic {
    SCAN_UP   = 1'b0,
    SCAN_DOWN = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/bscan_front.sv
// Width mask and direction fold: a downward scan becomes an upward scan of the reversed word.
module bscan_front
  import bscan_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned NARROW = HALF_W
) (
  input  logic [W-1:0] src_i,
  input  logic         size32_i,
  input  scan_dir_e    dir_i,
  output logic [W-1:0] scan_o,
  output logic         any_o
);
  logic [W-1:0] active_w;
  logic [W-1:0] flip_w;

  always_comb begin
    active_w = src_i;
    if (!size32_i) active_w[W-1:NARROW] = '0;
  end

  for (genvar b = 0; b < W; b++) begin : g_flip
    assign flip_w[b] = active_w[W-1-b];
  end

  assign scan_o = (dir_i == SCAN_DOWN) ? flip_w : active_w;
  assign any_o  = |active_w;
endmodule

// File: rtl/bscan_ffs.sv
// Two-level lowest-set-bit encoder: per-group encode, then lowest non-empty group.
module bscan_ffs #(
  parameter int unsigned N    = 32,
  parameter int unsigned GRP  = 8,
  localparam int unsigned NG  = N / GRP,
  localparam int unsigned GW  = $clog2(GRP),
  localparam int unsigned PW  = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [PW-1:0] pos_o
);
  logic [NG-1:0] grp_any;
  logic [GW-1:0] grp_pos [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |vec_i[g*GRP +: GRP];
    always_comb begin
      grp_pos[g] = '0;
      for (int j = GRP - 1; j >= 0; j--) begin
        if (vec_i[g*GRP + j]) grp_pos[g] = GW'(j);
      end
    end
  end

  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (grp_any[g]) begin
        found_o = 1'b1;
        pos_o   = PW'(g * GRP) + PW'(grp_pos[g]);
      end
    end
  end
endmodule

// File: rtl/bscan_out.sv
// Result stage: holds the last written index so a zero source leaves it untouched.
module bscan_out #(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned IW      = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          found_i,
  input  logic [IW-1:0] idx_i,
  output logic [IW-1:0] idx_o,
  output logic          zf_o,
  output logic          wr_en_o,
  output logic          valid_o
);
  logic          wr_c;
  logic [IW-1:0] idx_q;
  logic          zf_q;

  assign wr_c = valid_i & found_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      zf_q  <= 1'b0;
    end else begin
      if (wr_c)    idx_q <= idx_i;
      if (valid_i) zf_q  <= ~found_i;
    end
  end

  if (REG_OUT) begin : g_reg
    logic wr_q;
    logic vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wr_q  <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        wr_q  <= wr_c;
        vld_q <= valid_i;
      end
    end
    assign idx_o   = idx_q;
    assign zf_o    = zf_q;
    assign wr_en_o = wr_q;
    assign valid_o = vld_q;
  end else begin : g_comb
    assign idx_o   = wr_c ? idx_i : idx_q;
    assign zf_o    = valid_i ? ~found_i : zf_q;
    assign wr_en_o = wr_c;
    assign valid_o = valid_i;
  end
endmodule

// File: rtl/bit_scan_unit.sv
module bit_scan_unit
  import bscan_pkg::*;
#(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned GRP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              rev_i,
  input  logic              size32_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              zf_o,
  output logic              wr_en_o,
  output logic              valid_o
);
  scan_dir_e dir_w;
  word_t     scan_w;
  logic      any_w;
  logic      found_w;
  idx_t      pos_w;
  idx_t      idx_w;

  assign dir_w = scan_dir_e'(rev_i);

  bscan_front #(.W(DATA_W), .NARROW(HALF_W)) u_front (
    .src_i   (src_i),
    .size32_i(size32_i),
    .dir_i   (dir_w),
    .scan_o  (scan_w),
    .any_o   (any_w)
  );

  bscan_ffs #(.N(DATA_W), .GRP(GRP_W)) u_ffs (
    .vec_i  (scan_w),
    .found_o(found_w),
    .pos_o  (pos_w)
  );

  // Mirror back; masked high half keeps narrow downward results below HALF_W.
  assign idx_w = (dir_w == SCAN_DOWN) ? (IDX_W'(DATA_W - 1) - pos_w) : pos_w;

  bscan_out #(.REG_OUT(REG_OUT), .IW(IDX_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .found_i(found_w & any_w),
    .idx_i  (idx_w),
    .idx_o  (idx_o),
    .zf_o   (zf_o),
    .wr_en_o(wr_en_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/bit_scan_unit_chk.sv
module bit_scan_unit_chk
  import bscan_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] src_i,
  input logic              rev_i,
  input logic              size32_i,
  input logic [IDX_W-1:0]  idx_o,
  input logic              zf_o,
  input logic              wr_en_o,
  input logic              valid_o
);
  word_t msk_c;
  assign msk_c = size32_i ? src_i : {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};

  if (REG_OUT) begin : g_chk
    assert_low_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !rev_i && (msk_c != '0)) |=>
        (($past(msk_c) >> idx_o) & word_t'(1)) == word_t'(1) &&
        ($past(msk_c) & ((word_t'(1) << idx_o) - word_t'(1))) == '0);

    assert_high_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && rev_i && (msk_c != '0)) |=> ($past(msk_c) >> idx_o) == word_t'(1));

    assert_narrow_idx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !size32_i) |=> (!wr_en_o || !idx_o[IDX_W-1]));

    assert_zero_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (zf_o == ($past(msk_c) == '0)));

    assert_hold_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_o |-> $stable(idx_o));

    assert_wr_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (msk_c == '0)) |=> !wr_en_o);

    assert_valid_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);

    assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && !wr_en_o && $stable(zf_o)));
  end

  always_comb begin
    if (!rst_ni) begin
      assert_reset_R8: assert (idx_o == '0 && !zf_o && !wr_en_o && !valid_o);
    end
  end
endmodule

bind bit_scan_unit bit_scan_unit_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/bit_scan_unit_tb.sv
`timescale 1ns/1ps
module bit_scan_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] src_i = '0;
  logic        rev_i = 1'b0;
  logic        size32_i = 1'b0;
  logic [4:0]  idx_o;
  logic        zf_o;
  logic        wr_en_o;
  logic        valid_o;

  int n_chk = 0;
  int n_err = 0;
  logic [4:0] mdl_idx = '0;
  logic       mdl_zf = 1'b0;
  bit         done = 1'b0;

  typedef struct {
    logic [4:0] idx;
    logic       zf;
    logic       wr;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk_i = ~clk_i;

  bit_scan_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i),
    .rev_i(rev_i), .size32_i(size32_i), .idx_o(idx_o), .zf_o(zf_o),
    .wr_en_o(wr_en_o), .valid_o(valid_o)
  );

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // Reference: R1/R2 search, R3/R4 width, R5/R6 zero handling
  task automatic drive(input logic [31:0] s, input bit rv, input bit w32, input string tag);
    logic [31:0] act_w;
    exp_t e;
    @(negedge clk_i);
    valid_i = 1'b1; src_i = s; rev_i = rv; size32_i = w32;
    act_w = w32 ? s : {16'h0, s[15:0]};
    e.tag = tag;
    if (act_w == '0) begin
      e.zf = 1'b1; e.wr = 1'b0; e.idx = mdl_idx;
    end else begin
      e.zf = 1'b0; e.wr = 1'b1;
      if (rv) begin
        for (int b = 0; b < 32; b++) if (act_w[b]) e.idx = 5'(b);
      end else begin
        for (int b = 31; b >= 0; b--) if (act_w[b]) e.idx = 5'(b);
      end
      mdl_idx = e.idx;
    end
    mdl_zf = e.zf;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      src_i = $urandom();
    end
  endtask

  // Monitor: R7 latency, compare results
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected valid_o", "1", "0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(idx_o == e.idx && zf_o == e.zf && wr_en_o == e.wr, e.tag,
              $sformatf("idx=%0d zf=%0b wr=%0b", idx_o, zf_o, wr_en_o),
              $sformatf("idx=%0d zf=%0b wr=%0b", e.idx, e.zf, e.wr));
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(idx_o == 0 && !zf_o && !wr_en_o && !valid_o, "R8 reset state",
          $sformatf("%0d%0b%0b%0b", idx_o, zf_o, wr_en_o, valid_o), "0000");
    rst_ni = 1'b1;
    idle(2);

    drive(32'h0000_0001, 1'b0, 1'b1, "R1 up bit0");
    drive(32'h0F00_0100, 1'b0, 1'b1, "R1 up mid");
    drive(32'h8000_0000, 1'b0, 1'b1, "R4 up bit31");
    drive(32'h8000_0001, 1'b1, 1'b1, "R2 down bit31");
    drive(32'h0000_0001, 1'b1, 1'b1, "R2 down bit0");
    drive(32'h0F00_0100, 1'b1, 1'b1, "R2 down mid");
    drive(32'h0000_0000, 1'b0, 1'b1, "R6 zero keeps idx");
    drive(32'hFFFF_0000, 1'b1, 1'b0, "R3 high half ignored R5");
    drive(32'hABCD_8000, 1'b1, 1'b0, "R3 down narrow bit15");
    drive(32'hFFFF_0002, 1'b0, 1'b0, "R3 up narrow");
    drive(32'hFFFF_0002, 1'b1, 1'b0, "R3 down narrow ignores high");
    drive(32'h0001_0000, 1'b0, 1'b1, "R4 up bit16");
    drive(32'h0000_0000, 1'b1, 1'b0, "R5 zero narrow");
    idle(3);
    // R9: idle keeps idx and zf
    check(!valid_o && !wr_en_o && idx_o == mdl_idx && zf_o == mdl_zf, "R9 idle hold",
          $sformatf("idx=%0d zf=%0b wr=%0b", idx_o, zf_o, wr_en_o),
          $sformatf("idx=%0d zf=%0b wr=0", mdl_idx, mdl_zf));

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom();
      case (i % 5)
        0: r = r & (32'h1 << (i % 32));
        1: r = r & 32'hFFFF_0000;
        2: r = '0;
        default: ;
      endcase
      drive(r, 1'(i % 2), 1'(($urandom() >> 3) & 1), "R1 R2 R5 random");
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    check(sb_q.size() == 0, "R7 results drained", $sformatf("%0d", sb_q.size()), "0");
    check(idx_o == mdl_idx && zf_o == mdl_zf, "R9 final hold",
          $sformatf("idx=%0d zf=%0b", idx_o, zf_o), $sformatf("idx=%0d zf=%0b", mdl_idx, mdl_zf));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule